// File: doc/BRIEF.md
# Serial Control Port with Status Readback

This block is a serial slave for a three-wire control link: a chip select (active low), a serial clock and a serial data input. A host shifts in frames of sixteen bits. Each frame holds a 7-bit register address and then a 9-bit data word, most significant bit first. The block commits the frame to a small bank of control registers when chip select rises. The serial lines are oversampled by a faster system clock, and each one passes through a two-flop synchronizer first.

Register 0 sets up status readback. Bit 0 enables readback, bit 1 selects the continuous method, and bits [4:2] choose one of eight status byte inputs. When both mode bits are set, every frame returns the chosen status byte on a separate serial output. This includes frames sent to addresses that hold no register. The byte is taken when chip select falls and shifted out while the data field arrives. A mode pin puts the port in pin-controlled operation, in which all serial traffic is ignored.

Top module: `serCtlPort`

## Requirements
- R1: The data input is sampled on rising serial clock edges, most significant bit first. The first 7 bits form the address and the next 9 bits form the data word.
- R2: When chip select rises after exactly 16 rising clock edges, the data word is written to register `addr` for every address below NUM_REGS (4). Register n is visible on `ctlWords[n*9 +: 9]`.
- R3: A frame that has any bit count other than 16 when chip select rises changes no register.
- R4: A frame sent to an address at or above NUM_REGS (for example 0x55) changes no register.
- R5: After reset all registers read zero and `sdo` is low.
- R6: Readback happens only when register 0 bit 0 (enable) and bit 1 (continuous method) are both 1 when chip select falls. Otherwise `sdo` stays low for the whole frame.
- R7: The byte returned is `statusIn[sel*8 +: 8]`, where sel is register 0 bits [4:2]. It is captured when chip select falls. It is sent MSB first, one bit after each falling clock edge that follows rising edges 7 to 14, so the host reads it on rising edges 8 to 15.
- R8: `sdo` is low while chip select is high.
- R9: While `hwMode` is high, frames write no register and return no status.
- R10: When readback is set up, every frame returns the selected status, whatever its address, including addresses with no register behind them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Asynchronous reset, active low |
| hwMode | input | 1 | High selects pin control; the serial port then ignores all traffic |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Chip select, active low; its rising edge commits the frame |
| sdi | input | 1 | Serial data in |
| statusIn | input | NUM_STAT*STAT_W (64) | Read-only status bytes; byte k is at bits [k*8 +: 8] |
| sdo | output | 1 | Serial status output |
| ctlWords | output | NUM_REGS*DATA_W (36) | Control register contents; register n is at bits [n*9 +: 9] |

## Verification
Writes of distinct data patterns go to every real register and to a dummy address. Comparing the register outputs shows address decoding and bit order apart from stray writes. Frames of 15 and 17 bits, and frames sent with the mode pin high, must leave the registers untouched, which tests the length gate and the pin-control gate. The readback configuration is swept through enable only, method only, both bits set, and every value of the select field. The status bytes hold different values, so the scoreboard catches a wrong byte, wrong bit order or output from a port that should stay quiet.

// File: rtl/scpPkg.sv
package scpPkg;
  // Strobes from the frame controller to the datapath, one cycle wide.
  typedef struct packed {
    logic captureEn;  // chip select fell: snapshot status and config
    logic shiftEn;    // rising serial clock: shift data input in
    logic driveEn;    // falling serial clock: present next output bit
    logic commitEn;   // chip select rose after a full frame
    logic clearOut;   // chip select changed: force output low
  } scpStrobe_t;
endpackage

// File: rtl/scpSync.sv
module scpSync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RST_VAL;
      syncOut <= RST_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/scpCtrl.sv
module scpCtrl
  import scpPkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwMode,
  input  logic             sclkS,
  input  logic             csS,
  output scpStrobe_t       stb,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic sclkPrev, csPrev;
  logic sclkRise, sclkFall, csFall, csRise, active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign csFall   = ~csS & csPrev;
  assign csRise   = csS & ~csPrev;
  assign active   = ~csS & ~hwMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (active && sclkRise && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.captureEn = csFall & ~hwMode;
    stb.shiftEn   = active & sclkRise & ~csFall;
    stb.driveEn   = active & sclkFall & ~csFall;
    stb.commitEn  = csRise & ~hwMode & (bitCnt == CNT_FULL);
    stb.clearOut  = csRise | csFall;
  end
endmodule

// File: rtl/scpDpath.sv
module scpDpath
  import scpPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9,
  parameter int STAT_W   = 8,
  parameter int NUM_STAT = 8,
  parameter int NUM_REGS = 4,
  parameter int CNT_W    = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sdiS,
  input  scpStrobe_t                   stb,
  input  logic [CNT_W-1:0]             bitCnt,
  input  logic [NUM_STAT*STAT_W-1:0]   statusIn,
  output logic                         sdo,
  output logic [NUM_REGS*DATA_W-1:0]   ctlWords
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int SEL_W   = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1;
  localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(ADDR_W + STAT_W);

  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  regFile [NUM_REGS];
  logic [STAT_W-1:0]  outShift;
  logic               armed;
  logic [ADDR_W-1:0]  addrField;
  logic [DATA_W-1:0]  dataField;
  logic               cfgReadEn, cfgContRead;
  logic [SEL_W-1:0]   cfgSel;
  logic               inWindow;

  assign addrField   = shiftReg[FRAME_W-1 -: ADDR_W];
  assign dataField   = shiftReg[DATA_W-1:0];
  assign cfgReadEn   = regFile[0][0];
  assign cfgContRead = regFile[0][1];
  assign cfgSel      = regFile[0][2 +: SEL_W];
  assign inWindow    = (bitCnt >= WIN_LO) && (bitCnt < WIN_HI);

  // Frame shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], sdiS};
  end

  // Control register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (stb.commitEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addrField == ADDR_W'(i)) regFile[i] <= dataField;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gOut
      assign ctlWords[g*DATA_W +: DATA_W] = regFile[g];
    end
  endgenerate

  // Status snapshot and serial return
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      armed    <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      if (stb.captureEn) begin
        outShift <= statusIn[cfgSel*STAT_W +: STAT_W];
        armed    <= cfgReadEn & cfgContRead;
      end
      if (stb.clearOut) begin
        sdo <= 1'b0;
      end else if (stb.driveEn) begin
        if (inWindow) begin
          sdo      <= armed & outShift[STAT_W-1];
          outShift <= {outShift[STAT_W-2:0], 1'b0};
        end else begin
          sdo <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serCtlPort.sv
module serCtlPort
  import scpPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9,
  parameter int STAT_W   = 8,
  parameter int NUM_STAT = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hwMode,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       sdi,
  input  logic [NUM_STAT*STAT_W-1:0] statusIn,
  output logic                       sdo,
  output logic [NUM_REGS*DATA_W-1:0] ctlWords
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [2:0]       syncBus;
  logic             sclkS, csS, sdiS;
  scpStrobe_t       stb;
  logic [CNT_W-1:0] bitCnt;

  scpSync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclk, csN, sdi}),
    .syncOut(syncBus)
  );
  assign {sclkS, csS, sdiS} = syncBus;

  scpCtrl #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hwMode(hwMode),
    .sclkS(sclkS), .csS(csS), .stb(stb), .bitCnt(bitCnt)
  );

  scpDpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .NUM_STAT(NUM_STAT), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .sdiS(sdiS), .stb(stb), .bitCnt(bitCnt),
    .statusIn(statusIn), .sdo(sdo), .ctlWords(ctlWords)
  );
endmodule

// File: rtl/scpChk.sv
module scpChk
  import scpPkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int NUM_REGS = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       hwMode,
  input logic                       csS,
  input logic                       sdo,
  input scpStrobe_t                 stb,
  input logic [NUM_REGS*DATA_W-1:0] ctlWords
);
  // R9: pin-control mode freezes the register bank
  assert_hw_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(hwMode) |-> $stable(ctlWords));

  // R8: output quiet once chip select has been high two samples
  assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !sdo);

  // R2/R3: registers only change right after a commit strobe
  assert_commit_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlWords) |-> $past(stb.commitEn));

  // R6: a high output implies readback is configured
  assert_rb_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    sdo |-> (ctlWords[0] && ctlWords[1]));

  // R1: strobes are mutually exclusive
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftEn, stb.driveEn, stb.commitEn}));
endmodule

bind serCtlPort scpChk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .hwMode(hwMode), .csS(csS),
  .sdo(sdo), .stb(stb), .ctlWords(ctlWords)
);

// File: tb/serCtlPort_tb.sv
module serCtlPort_tb;
  localparam int NREG = 4;
  localparam int HP   = 8;

  logic clk = 0, rstN = 0, hwMode = 0, sclk = 0, csN = 1, sdi = 0;
  logic [63:0] statusIn;
  logic        sdo;
  logic [NREG*9-1:0] ctlWords;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [8:0] model [NREG];

  typedef struct { logic [7:0] b; bit chk; } exp_t;
  exp_t expQ[$];

  int rcount = 0;
  logic [7:0] got = 0;

  always #5 clk = ~clk;

  serCtlPort u_dut (
    .clk(clk), .rstN(rstN), .hwMode(hwMode), .sclk(sclk), .csN(csN),
    .sdi(sdi), .statusIn(statusIn), .sdo(sdo), .ctlWords(ctlWords)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitHp(input int n);
    repeat (n * HP) @(negedge clk);
  endtask

  // Driver: sends a frame and pushes the expected readback byte
  task automatic frame(input logic [6:0] addr, input logic [8:0] data, input int nbits);
    logic [15:0] word;
    exp_t e;
    word = {addr, data};
    e.chk = (nbits >= 15);
    e.b = (model[0][0] && model[0][1] && !hwMode) ? statusIn[model[0][4:2]*8 +: 8] : 8'h00;
    expQ.push_back(e);
    csN = 0;
    waitHp(3);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b0;
      waitHp(1);
      sclk = 1;
      waitHp(1);
      sclk = 0;
    end
    waitHp(1);
    csN = 1;
    waitHp(4);
    if (nbits == 16 && !hwMode && addr < NREG) model[addr] = data;
    for (int r = 0; r < NREG; r++)
      check("R2/R3/R4/R9 reg", ctlWords[r*9 +: 9], model[r]);
    check("R8 sdo idle", sdo, 0);
  endtask

  // Monitor: collect returned bits, compare at end of frame
  always @(negedge csN) begin rcount = 0; got = 0; end
  always @(posedge sclk) if (!csN) begin
    rcount++;
    if (rcount >= 8 && rcount <= 15) got = {got[6:0], sdo};
  end
  always @(posedge csN) if (expQ.size() > 0) begin
    exp_t e;
    e = expQ.pop_front();
    if (e.chk) check("R6/R7/R10 readback", got, e.b);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) statusIn[k*8 +: 8] = 8'hA5 ^ (8'(k) * 8'h3B);
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    check("R5 regs reset", ctlWords, 0);
    check("R5 sdo reset", sdo, 0);

    frame(7'd1, 9'h1A5, 16);          // R1 R2 bit order
    frame(7'd2, 9'h05A, 16);          // R2
    frame(7'd3, 9'h100, 16);          // R2 msb of data
    frame(7'd0, 9'h001, 16);          // enable only
    frame(7'd1, 9'h0F0, 16);          // R6 no return: method bit off
    frame(7'd0, 9'h002, 16);          // method only
    frame(7'd2, 9'h033, 16);          // R6 no return: enable off
    frame(7'd0, 9'h00F, 16);          // both, sel=3
    frame(7'd2, 9'h0C3, 16);          // R7 returns status 3
    frame(7'h55, 9'h1FF, 16);         // R4 R10 dummy address
    frame(7'd1, 9'h111, 15);          // R3 short frame
    frame(7'd1, 9'h122, 17);          // R3 long frame
    hwMode = 1;
    frame(7'd0, 9'h000, 16);          // R9 ignored, no return
    frame(7'd3, 9'h0AA, 16);          // R9
    hwMode = 0;
    for (int s = 0; s < 8; s++) begin // R7 every select value
      frame(7'd0, 9'(3 | (s << 2)), 16);
      frame(7'h7F, 9'h000, 16);       // R10 dummy triggers return
    end
    frame(7'd0, 9'h000, 16);          // readback off again
    frame(7'd2, 9'h155, 16);          // R6 quiet

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule